// File: doc/BRIEF.md
# Interlocked Byte Link Host Engine

This block is the host end of a byte-wide parallel link to a peripheral processor. One 8-bit port carries bytes out to the peripheral and a second carries bytes back. Every byte moves under a fully interlocked four-phase handshake. The host drives four lines: data-valid, ready-for-data, data-accepted and attention. The peripheral answers on its own data-valid, ready-for-data and data-accepted lines. On the host side the engine accepts bytes to send through a valid/ready stream. It returns each received byte as a one-cycle valid pulse.

A send drives the byte onto the outbound port and waits until the peripheral reports that it is ready. The engine then raises data-valid and holds it until the peripheral accepts the byte. It then drops data-valid and waits for the peripheral to drop its acknowledge. A receive raises ready-for-data and waits for the peripheral's data-valid. It then captures the inbound byte and raises data-accepted until the peripheral releases its strobe.

A byte tagged as a command raises attention. An abort request also raises attention and returns every host strobe low at once. In both cases attention stays high until the peripheral has accepted the next outbound byte. All three peripheral strobes pass through a synchronizer chain before the state machine uses them. A stall counter flags any wait on the peripheral that has not moved for a set number of cycles.

Top module: `plink_host`

## Requirements
- R1: During and straight after reset the host drives attention, data-valid, ready-for-data and data-accepted low, rx_valid and stalled are low, and tx_ready is high.
- R2: A byte is taken when tx_valid and tx_ready are both high at a clock edge, and appears on link_dout after that edge. link_dav stays low until the synchronized peer_rfd is seen high. Every byte taken reaches the peripheral in order.
- R3: link_dav falls only after the synchronized peer_dac has been seen high. tx_ready stays low until the synchronized peer_dac has been seen low again.
- R4: link_dout holds its value from the rise of link_dav until the engine is ready for the next byte, which comes after peer_dac falls.
- R5: When idle with rx_ready high and tx_valid low, the engine raises link_rfd. When it sees the synchronized peer_dav, it captures peer_din into rx_data and pulses rx_valid for exactly one cycle. It also swaps link_rfd for link_dac, and drops link_dac only after peer_dav is seen low.
- R6: When idle, a pending tx_valid takes priority over rx_ready: link_rfd stays low and the byte is taken.
- R7: A byte taken with tx_cmd high raises link_atn from the acceptance edge. link_atn stays high until the synchronized peer_dac for an outbound byte is seen, and falls at that point.
- R8: A cycle with abort_req high gives, from the next edge, link_atn high and all three host strobes low. The engine reports ready only after the synchronized peer_dav and peer_dac are both low. link_atn stays high until the peripheral accepts the next outbound byte.
- R9: At most one of link_dav, link_rfd and link_dac is high in any cycle.
- R10: A change on a peer strobe affects the host lines exactly SYNC_STAGES+1 clock edges later: two synchronizer flops, then the state register.
- R11: stalled rises when the engine has waited on the peripheral for STALL_LIMIT edges with no state change. It falls at the edge where the state changes, and is low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Outbound byte offered |
| tx_cmd | input | 1 | Offered byte starts a command (raises attention) |
| tx_data | input | DATA_W | Outbound byte |
| tx_ready | output | 1 | Engine idle and able to take a byte |
| rx_ready | input | 1 | Host wants a byte from the peripheral |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new byte |
| rx_data | output | DATA_W | Last byte received |
| abort_req | input | 1 | Abort the current handshake and raise attention |
| stalled | output | 1 | Wait on the peripheral exceeded STALL_LIMIT cycles |
| link_atn | output | 1 | Attention line to the peripheral |
| link_dav | output | 1 | Host data-valid |
| link_rfd | output | 1 | Host ready-for-data |
| link_dac | output | 1 | Host data-accepted |
| link_dout | output | DATA_W | Outbound data port |
| peer_dav | input | 1 | Peripheral data-valid (asynchronous) |
| peer_rfd | input | 1 | Peripheral ready-for-data (asynchronous) |
| peer_dac | input | 1 | Peripheral data-accepted (asynchronous) |
| peer_din | input | DATA_W | Inbound data port |

## Verification
The hardest state to reach from the ports is an abort that arrives while a handshake is half done. The peripheral still holds its own strobe high, so the engine must sit in its abort wait with every host line low. The bench gets there by driving the peripheral lines by hand: it completes a receive up to the point where host data-accepted is high, pulses abort, and keeps the peripheral's data-valid asserted for several more cycles. It then releases that strobe and counts edges until ready returns. Exact edge counts through the synchronizer are checked the same way, alongside a randomized phase in which a reactive peripheral model inserts random delays into every phase of both directions.

// File: rtl/plink_pkg.sv
package plink_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_TX_ARM     = 3'd1,
        ST_TX_STROBE  = 3'd2,
        ST_TX_RELEASE = 3'd3,
        ST_RX_ARM     = 3'd4,
        ST_RX_RELEASE = 3'd5,
        ST_ABORT      = 3'd6
    } plink_state_e;

    // One bundle of the three handshake strobes, used for both directions.
    typedef struct packed {
        logic dav;
        logic rfd;
        logic dac;
    } plink_strobes_t;

    localparam int STROBE_W = $bits(plink_strobes_t);

    // Host strobes are a pure decode of the state register.
    function automatic plink_strobes_t strobes_of(plink_state_e s);
        plink_strobes_t r;
        r = '0;
        case (s)
            ST_TX_STROBE:  r.dav = 1'b1;
            ST_RX_ARM:     r.rfd = 1'b1;
            ST_RX_RELEASE: r.dac = 1'b1;
            default:       r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/plink_sync.sv
module plink_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_stage[g-1].q;
            end
        end
    end

    assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/plink_watch.sv
module plink_watch #(
    parameter int STALL_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic progress,
    output logic stalled
);

    localparam int CW = $clog2(STALL_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(STALL_LIMIT);

    logic [CW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst || !busy || progress) begin
            wait_q <= '0;
        end else if (wait_q != LIMIT_V) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    assign stalled = (wait_q == LIMIT_V);

    // R11
    stall_idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy || progress) |=> !stalled);

endmodule

// File: rtl/plink_ctrl.sv
module plink_ctrl
    import plink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic              tx_cmd,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              abort_req,
    input  plink_strobes_t    peer_s,
    input  logic [DATA_W-1:0] peer_din,
    output logic              link_atn,
    output plink_strobes_t    link_s,
    output logic [DATA_W-1:0] link_dout,
    output logic              busy,
    output logic              progress
);

    plink_state_e      state_q, state_d;
    logic [DATA_W-1:0] dout_q, rx_data_q;
    logic              rx_valid_q, atn_q;
    logic              tx_take, rx_take, peer_acked;

    assign tx_ready   = (state_q == ST_IDLE) && !abort_req;
    assign tx_take    = tx_ready && tx_valid;
    assign rx_take    = (state_q == ST_RX_ARM) && peer_s.dav && !abort_req;
    assign peer_acked = (state_q == ST_TX_STROBE) && peer_s.dac;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_valid)      state_d = ST_TX_ARM;
                else if (rx_ready) state_d = ST_RX_ARM;
            end
            ST_TX_ARM:     if (peer_s.rfd)  state_d = ST_TX_STROBE;
            ST_TX_STROBE:  if (peer_s.dac)  state_d = ST_TX_RELEASE;
            ST_TX_RELEASE: if (!peer_s.dac) state_d = ST_IDLE;
            ST_RX_ARM:     if (peer_s.dav)  state_d = ST_RX_RELEASE;
            ST_RX_RELEASE: if (!peer_s.dav) state_d = ST_IDLE;
            ST_ABORT:      if (!peer_s.dav && !peer_s.dac) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
        if (abort_req && state_q != ST_ABORT) state_d = ST_ABORT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            dout_q     <= '0;
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
            atn_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            rx_valid_q <= rx_take;
            if (tx_take) dout_q    <= tx_data;
            if (rx_take) rx_data_q <= peer_din;
            if (abort_req)                 atn_q <= 1'b1;
            else if (tx_take && tx_cmd)    atn_q <= 1'b1;
            else if (peer_acked)           atn_q <= 1'b0;
        end
    end

    assign link_s    = strobes_of(state_q);
    assign link_dout = dout_q;
    assign link_atn  = atn_q;
    assign rx_valid  = rx_valid_q;
    assign rx_data   = rx_data_q;
    assign busy      = (state_q != ST_IDLE);
    assign progress  = (state_d != state_q);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({link_s.dav, link_s.rfd, link_s.dac}));

    // R4
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        link_s.dav |=> $stable(link_dout));

    // R3
    dav_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(link_s.dav) && !$past(abort_req)) |-> $past(peer_s.dac));

    // R8
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> (link_atn && !link_s.dav && !link_s.rfd && !link_s.dac));

    // R5
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    atn_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_atn) |-> $past(peer_s.dac));

endmodule

// File: rtl/plink_host.sv
module plink_host
    import plink_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STALL_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic              tx_cmd,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              abort_req,
    output logic              stalled,
    output logic              link_atn,
    output logic              link_dav,
    output logic              link_rfd,
    output logic              link_dac,
    output logic [DATA_W-1:0] link_dout,
    input  logic              peer_dav,
    input  logic              peer_rfd,
    input  logic              peer_dac,
    input  logic [DATA_W-1:0] peer_din
);

    plink_strobes_t       peer_raw, peer_s, host_s;
    logic [STROBE_W-1:0]  peer_sync_bits;
    logic                 busy, progress;

    assign peer_raw = '{dav: peer_dav, rfd: peer_rfd, dac: peer_dac};

    plink_sync #(
        .WIDTH  (STROBE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (peer_raw),
        .dout (peer_sync_bits)
    );

    assign peer_s = peer_sync_bits;

    plink_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tx_valid  (tx_valid),
        .tx_cmd    (tx_cmd),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rx_ready  (rx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .abort_req (abort_req),
        .peer_s    (peer_s),
        .peer_din  (peer_din),
        .link_atn  (link_atn),
        .link_s    (host_s),
        .link_dout (link_dout),
        .busy      (busy),
        .progress  (progress)
    );

    plink_watch #(
        .STALL_LIMIT (STALL_LIMIT)
    ) u_watch (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .progress (progress),
        .stalled  (stalled)
    );

    assign link_dav = host_s.dav;
    assign link_rfd = host_s.rfd;
    assign link_dac = host_s.dac;

endmodule

// File: tb/plink_host_tb.sv
module plink_host_tb_top;

    localparam int CLK_PERIOD_NS = 10;
    localparam int DW            = 8;
    localparam int STALL         = 12;
    localparam int NOPS          = 60;
    localparam int QDEPTH        = 128;

    logic          clk = 1'b0;
    logic          rst;
    logic          tx_valid, tx_cmd, tx_ready;
    logic [DW-1:0] tx_data;
    logic          rx_ready, rx_valid;
    logic [DW-1:0] rx_data;
    logic          abort_req, stalled;
    logic          link_atn, link_dav, link_rfd, link_dac;
    logic [DW-1:0] link_dout;
    logic          peer_dav, peer_rfd, peer_dac;
    logic [DW-1:0] peer_din;

    int checks = 0;
    int fails  = 0;
    int overlap = 0;

    bit            peer_auto = 1'b0;
    logic [DW-1:0] exp_tx  [QDEPTH];
    bit            exp_cmd [QDEPTH];
    logic [DW-1:0] peer_src[QDEPTH];
    int            n_pushed = 0;
    int            peer_got = 0;
    int            peer_sent = 0;
    int            rx_got = 0;

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    plink_host #(
        .DATA_W      (DW),
        .SYNC_STAGES (2),
        .STALL_LIMIT (STALL)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tx_valid  (tx_valid),
        .tx_cmd    (tx_cmd),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rx_ready  (rx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .abort_req (abort_req),
        .stalled   (stalled),
        .link_atn  (link_atn),
        .link_dav  (link_dav),
        .link_rfd  (link_rfd),
        .link_dac  (link_dac),
        .link_dout (link_dout),
        .peer_dav  (peer_dav),
        .peer_rfd  (peer_rfd),
        .peer_dac  (peer_dac),
        .peer_din  (peer_din)
    );

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int expect_atn(int idx);
        return exp_cmd[idx] ? 1 : 0;
    endfunction

    // Strobe overlap monitor (R9)
    always @(negedge clk) begin
        if (rst === 1'b0 && (int'(link_dav) + int'(link_rfd) + int'(link_dac)) > 1)
            overlap++;
    end

    // Reactive peripheral model with random delays
    always @(negedge clk) begin
        if (peer_auto && !rst) begin
            peer_rfd = 1'b1;
            if (link_dav && !peer_dac && ($urandom % 4) != 0) begin
                check_eq("R2 byte at peer", int'(link_dout), int'(exp_tx[peer_got]));
                check_eq("R7 atn matches command flag", int'(link_atn), expect_atn(peer_got));
                peer_dac = 1'b1;
                peer_got++;
            end else if (peer_dac && !link_dav && ($urandom % 4) != 0) begin
                check_eq("R4 dout held to release", int'(link_dout), int'(exp_tx[peer_got-1]));
                peer_dac = 1'b0;
            end
            if (link_rfd && !peer_dav && ($urandom % 4) != 0) begin
                peer_din = peer_src[peer_sent];
                peer_dav = 1'b1;
            end else if (peer_dav && link_dac && ($urandom % 4) != 0) begin
                peer_dav = 1'b0;
                peer_sent++;
                peer_din = DW'($urandom);
            end
        end
    end

    task automatic send_byte(logic [DW-1:0] b, bit c);
        exp_tx[n_pushed]  = b;
        exp_cmd[n_pushed] = c;
        n_pushed++;
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = b;
        tx_cmd   = c;
        wait_edges(1);
        tx_valid = 1'b0;
        tx_cmd   = 1'b0;
    endtask

    task automatic recv_byte();
        while (!tx_ready) @(negedge clk);
        rx_ready = 1'b1;
        while (!rx_valid) @(negedge clk);
        check_eq("R5 received byte", int'(rx_data), int'(peer_src[rx_got]));
        rx_got++;
        rx_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual=hung expected=finished at %0t", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < QDEPTH; i++) peer_src[i] = DW'($urandom);
        rst = 1'b1;
        tx_valid = 0; tx_cmd = 0; tx_data = '0; rx_ready = 0; abort_req = 0;
        peer_dav = 0; peer_rfd = 0; peer_dac = 0; peer_din = '0;

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 atn in reset", int'(link_atn), 0);
        check_eq("R1 strobes in reset", int'({link_dav, link_rfd, link_dac}), 0);
        check_eq("R1 tx_ready in reset", int'(tx_ready), 1);
        check_eq("R1 rx_valid/stalled in reset", int'({rx_valid, stalled}), 0);
        rst = 1'b0;
        wait_edges(1);
        check_eq("R1 strobes after reset", int'({link_atn, link_dav, link_rfd, link_dac}), 0);

        // Directed send with stall, latency and release (R2 R3 R4 R10 R11)
        tx_valid = 1'b1; tx_data = 8'hA5;
        wait_edges(1);
        tx_valid = 1'b0;
        check_eq("R2 byte on dout", int'(link_dout), 8'hA5);
        check_eq("R2 taken, not ready", int'(tx_ready), 0);
        wait_edges(STALL - 1);
        check_eq("R11 stalled before limit", int'(stalled), 0);
        check_eq("R2 no dav without peer rfd", int'(link_dav), 0);
        wait_edges(1);
        check_eq("R11 stalled at limit", int'(stalled), 1);
        peer_rfd = 1'b1;
        wait_edges(2);
        check_eq("R10 dav low after two edges", int'(link_dav), 0);
        wait_edges(1);
        check_eq("R10 dav high after three edges", int'(link_dav), 1);
        check_eq("R11 stalled clears on progress", int'(stalled), 0);
        peer_dac = 1'b1;
        wait_edges(2);
        check_eq("R3 dav held before ack seen", int'(link_dav), 1);
        wait_edges(1);
        check_eq("R3 dav drops after ack", int'(link_dav), 0);
        check_eq("R4 dout held after dav fall", int'(link_dout), 8'hA5);
        wait_edges(4);
        check_eq("R3 not ready while peer dac high", int'(tx_ready), 0);
        peer_dac = 1'b0;
        wait_edges(3);
        check_eq("R3 ready after peer dac low", int'(tx_ready), 1);

        // Directed receive, then abort mid-handshake (R5 R8 R7)
        peer_rfd = 1'b0;
        rx_ready = 1'b1;
        wait_edges(1);
        check_eq("R5 rfd raised", int'(link_rfd), 1);
        peer_din = 8'h3C; peer_dav = 1'b1;
        wait_edges(2);
        check_eq("R5 no capture before sync", int'(rx_valid), 0);
        wait_edges(1);
        check_eq("R5 rx_valid pulse", int'(rx_valid), 1);
        check_eq("R5 captured byte", int'(rx_data), 8'h3C);
        check_eq("R5 dac replaces rfd", int'({link_rfd, link_dac}), 1);
        rx_ready = 1'b0;
        peer_din = 8'hFF;
        wait_edges(1);
        check_eq("R5 pulse is one cycle", int'(rx_valid), 0);
        check_eq("R5 data held", int'(rx_data), 8'h3C);
        abort_req = 1'b1;
        wait_edges(1);
        abort_req = 1'b0;
        check_eq("R8 atn on abort", int'(link_atn), 1);
        check_eq("R8 strobes low on abort", int'({link_dav, link_rfd, link_dac}), 0);
        wait_edges(5);
        check_eq("R8 waits for peer dav low", int'(tx_ready), 0);
        peer_dav = 1'b0;
        wait_edges(2);
        check_eq("R8 still waiting in sync", int'(tx_ready), 0);
        wait_edges(1);
        check_eq("R8 ready after peer release", int'(tx_ready), 1);
        check_eq("R8 atn held after abort", int'(link_atn), 1);
        peer_rfd = 1'b1;
        wait_edges(3);
        tx_valid = 1'b1; tx_data = 8'h5A;
        wait_edges(1);
        tx_valid = 1'b0;
        wait_edges(1);
        check_eq("R8 atn during next byte", int'({link_atn, link_dav}), 3);
        peer_dac = 1'b1;
        wait_edges(3);
        check_eq("R7 atn drops on ack", int'(link_atn), 0);
        peer_dac = 1'b0;
        wait_edges(3);

        // Priority and command start with the reactive peer (R6 R7)
        peer_auto = 1'b1;
        exp_tx[n_pushed] = 8'hC3; exp_cmd[n_pushed] = 1'b1; n_pushed++;
        tx_valid = 1'b1; tx_data = 8'hC3; tx_cmd = 1'b1; rx_ready = 1'b1;
        wait_edges(1);
        check_eq("R6 rfd stays low", int'(link_rfd), 0);
        check_eq("R6 byte taken", int'(tx_ready), 0);
        check_eq("R7 atn from command", int'(link_atn), 1);
        tx_valid = 1'b0; tx_cmd = 1'b0; rx_ready = 1'b0;
        while (!tx_ready) @(negedge clk);
        check_eq("R7 atn low after command byte", int'(link_atn), 0);

        // Random mix
        for (int i = 0; i < NOPS; i++) begin
            int op;
            op = int'($urandom % 3);
            if (op < 2) send_byte(DW'($urandom), ($urandom % 4) == 0);
            else        recv_byte();
            repeat ($urandom % 3) @(negedge clk);
        end
        wait_edges(30);
        check_eq("R2 all bytes delivered", peer_got, n_pushed);
        check_eq("R9 strobe overlap cycles", overlap, 0);
        check_eq("R11 idle not stalled", int'(stalled), 0);
        finish_run();
    end

endmodule